// File: doc/BRIEF.md
# Sampling converter read controller

This block is the host-side master for a 12-bit serial sampling converter. A start request makes it drive the conversion-start pin low for a short strobe and then wait out the converter's conversion time. After that it issues exactly sixteen serial clock pulses and captures the data line on every falling serial clock edge. The first four bits of each frame must be zero. They are dropped and only checked, and the remaining twelve bits are presented as the result, most significant bit first, together with a one-cycle done strobe.

The controller enforces the converter's sequencing rules by construction. The serial clock is low whenever conversion-start falls. It stays low for the whole conversion and between reads. A guard interval always separates the last serial clock edge of one read from the next conversion-start fall. The wait counts are derived from a system clock frequency parameter. The serial clock half-period comes from a divider input. A request that arrives while a read is in flight is remembered and served once the block is idle again.

Top module: `sar_rd_host`

## Requirements
- R1: An accepted start request drives `cnv_n` low on the next clock edge, and it stays low for exactly CNV_LOW_CYC system clocks (default 4).
- R2: `sclk` is low when `cnv_n` falls and throughout the conversion. The first `sclk` rising edge comes exactly CONV_CYC + (div_sel+1) system clocks after the `cnv_n` fall, where CONV_CYC is CONV_NS converted to clocks and rounded up (660 at 200 MHz).
- R3: Each read produces exactly 16 `sclk` pulses. Each pulse is high for div_sel+1 clocks and low for div_sel+1 clocks, so the span from the first rising to the last falling edge is 31·(div_sel+1) clocks.
- R4: `sdata` is sampled when `sclk` falls. Frame bits 15..12 are leading bits, and bits 11..0 form `result`, MSB received first.
- R5: `frame_err` is updated with each result and is 1 exactly when any of the four leading bits was 1.
- R6: `done` is high for exactly one clock, in the cycle right after the 16th `sclk` fall. `result` and `frame_err` hold their values until the next `done`.
- R7: When a request is waiting, the next `cnv_n` fall occurs exactly GUARD_CYC+1 clocks after the last `sclk` fall of the previous read, where GUARD_CYC is GUARD_NS in clocks rounded up (20 at 200 MHz).
- R8: Requests that arrive while the block is busy are merged into a single pending request. That request starts exactly one further conversion after the guard interval.
- R9: `sclk` is low whenever no read is in progress, and no conversion starts without a request.
- R10: After reset, `cnv_n`=1, `sclk`=0, `done`=0, `result`=0 and `frame_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Request one conversion and read |
| div_sel | input | DIV_W (4) | Serial clock half-period in system clocks, minus one; captured when the read begins |
| cnv_n | output | 1 | Conversion-start to the converter, active low |
| sclk | output | 1 | Serial clock to the converter |
| sdata | input | 1 | Serial data from the converter |
| result | output | FRAME_BITS-LEAD_BITS (12) | Last conversion result |
| done | output | 1 | One-cycle strobe when a new result is available |
| frame_err | output | 1 | Leading bits of the last frame were not all zero |

## Verification
The bench models the converter from the pin edges and measures every interval in system clocks. It checks the strobe width, the conversion wait, the pulse span, the pulse count and the guard gap against values computed from the parameters. A design that sampled on the rising edge, or that shifted one bit too few or too many, would misplace the result by one bit. The bench catches this with patterns whose neighbouring bits differ. Frames are sent with a single leading bit set, to catch a frame check that tests only some of the leading positions. Several requests are issued during a busy read, to catch a pending latch that drops requests or counts them twice. Two divider settings are used, to catch an off-by-one half-period that would stretch or shorten every pulse.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_CONV  = 2'd1,
    S_READ  = 2'd2,
    S_GUARD = 2'd3
  } seq_state_t;

  // nanoseconds to system clocks, rounded up so a wait is never short
  function automatic int unsigned ns_to_cyc(longint unsigned ns, longint unsigned hz);
    longint unsigned prod;
    prod = ns * hz + 64'd999_999_999;
    return int'(prod / 64'd1_000_000_000);
  endfunction

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
  import sar_rd_pkg::*;
#(
  parameter int unsigned CONV_CYC    = 660,
  parameter int unsigned GUARD_CYC   = 20,
  parameter int unsigned CNV_LOW_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic read_last,
  output logic launch,
  output logic go_read,
  output logic conv_busy,
  output logic quiet,
  output logic cnv_n
);
  localparam int unsigned MAXC  = max_u(CONV_CYC, GUARD_CYC);
  localparam int unsigned CNT_W = $clog2(MAXC + 1);

  seq_state_t       st;
  logic [CNT_W-1:0] cnt;
  logic             pend;
  logic             guard_end;

  assign launch    = (st == S_IDLE) && (start_req || pend);
  assign go_read   = (st == S_CONV) && (cnt == CNT_W'(CONV_CYC - 1));
  assign guard_end = (st == S_GUARD) && (cnt == CNT_W'(GUARD_CYC - 1));
  assign conv_busy = (st == S_CONV);
  assign quiet     = (st == S_IDLE) || (st == S_GUARD) || (st == S_CONV);
  assign cnv_n     = !((st == S_CONV) && (cnt < CNT_W'(CNV_LOW_CYC)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      if (launch)         pend <= 1'b0;
      else if (start_req) pend <= 1'b1;
      unique case (st)
        S_IDLE: if (launch) begin
          st  <= S_CONV;
          cnt <= '0;
        end
        S_CONV: if (go_read) begin
          st  <= S_READ;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_READ: if (read_last) begin
          st  <= S_GUARD;
          cnt <= '0;
        end
        S_GUARD: if (guard_end) begin
          st  <= S_IDLE;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // a request seen while busy must be remembered (R8)
  p_pend_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && start_req) |=> pend);

  // conversion strobe lasts at least two clocks once it falls (R1)
  p_strobe_min_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cnv_n) |=> !cnv_n);

endmodule

// File: rtl/sar_sclk_gen.sv
module sar_sclk_gen #(
  parameter int unsigned DIV_W      = 4,
  parameter int unsigned FRAME_BITS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [DIV_W-1:0] div,
  output logic             sclk,
  output logic             active,
  output logic             fall_evt,
  output logic             last_fall
);
  localparam int unsigned HW   = DIV_W + 1;
  localparam int unsigned PC_W = $clog2(FRAME_BITS);

  logic [HW-1:0]   hreg;
  logic [HW-1:0]   hc;
  logic [PC_W-1:0] pc;
  logic            tick;

  assign tick      = active && (hc == hreg - HW'(1));
  assign fall_evt  = tick && sclk;
  assign last_fall = fall_evt && (pc == PC_W'(FRAME_BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hreg   <= HW'(1);
      hc     <= '0;
      pc     <= '0;
      sclk   <= 1'b0;
      active <= 1'b0;
    end else if (go) begin
      hreg   <= {1'b0, div} + HW'(1);
      hc     <= '0;
      pc     <= '0;
      sclk   <= 1'b0;
      active <= 1'b1;
    end else if (active) begin
      if (tick) begin
        hc   <= '0;
        sclk <= ~sclk;
        if (fall_evt) pc <= pc + 1'b1;
        if (last_fall) active <= 1'b0;
      end else begin
        hc <= hc + 1'b1;
      end
    end
  end

  // once the gate closes the clock must already be low (R9)
  p_stop_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> !sclk);

endmodule

// File: rtl/sar_shift_rx.sv
module sar_shift_rx #(
  parameter int unsigned FRAME_BITS = 16,
  parameter int unsigned LEAD_BITS  = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           sample,
  input  logic                           last,
  input  logic                           sdata,
  output logic [FRAME_BITS-LEAD_BITS-1:0] result,
  output logic                           frame_err,
  output logic                           done
);
  localparam int unsigned DATA_W = FRAME_BITS - LEAD_BITS;

  logic [FRAME_BITS-2:0] sh;
  logic [FRAME_BITS-1:0] full;

  assign full = {sh, sdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh        <= '0;
      result    <= '0;
      frame_err <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (sample) sh <= {sh[FRAME_BITS-3:0], sdata};
      if (last) begin
        result    <= full[DATA_W-1:0];
        frame_err <= |full[FRAME_BITS-1 -: LEAD_BITS];
        done      <= 1'b1;
      end
    end
  end

  // a frame is only closed on a sampling edge (R4)
  p_last_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> sample);

endmodule

// File: rtl/sar_rd_host.sv
module sar_rd_host
  import sar_rd_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 200_000_000,
  parameter int unsigned CONV_NS     = 3300,
  parameter int unsigned GUARD_NS    = 100,
  parameter int unsigned CNV_LOW_CYC = 4,
  parameter int unsigned DIV_W       = 4,
  parameter int unsigned FRAME_BITS  = 16,
  parameter int unsigned LEAD_BITS   = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start_req,
  input  logic [DIV_W-1:0]                div_sel,
  output logic                            cnv_n,
  output logic                            sclk,
  input  logic                            sdata,
  output logic [FRAME_BITS-LEAD_BITS-1:0] result,
  output logic                            done,
  output logic                            frame_err
);
  localparam int unsigned DATA_W    = FRAME_BITS - LEAD_BITS;
  localparam int unsigned CONV_CYC  = ns_to_cyc(CONV_NS, CLK_HZ);
  localparam int unsigned GUARD_CYC = ns_to_cyc(GUARD_NS, CLK_HZ);
  localparam int unsigned RC_W      = $clog2(FRAME_BITS + 2);
  localparam int unsigned GC_W      = $clog2(GUARD_CYC + 2);

  // internal events brought out for the checks below
  logic launch, go_read, conv_busy, quiet;
  logic gen_active, fall_evt, last_fall;

  sar_seq_fsm #(
    .CONV_CYC   (CONV_CYC),
    .GUARD_CYC  (GUARD_CYC),
    .CNV_LOW_CYC(CNV_LOW_CYC)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_req(start_req),
    .read_last(last_fall),
    .launch   (launch),
    .go_read  (go_read),
    .conv_busy(conv_busy),
    .quiet    (quiet),
    .cnv_n    (cnv_n)
  );

  sar_sclk_gen #(
    .DIV_W     (DIV_W),
    .FRAME_BITS(FRAME_BITS)
  ) u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go_read),
    .div      (div_sel),
    .sclk     (sclk),
    .active   (gen_active),
    .fall_evt (fall_evt),
    .last_fall(last_fall)
  );

  sar_shift_rx #(
    .FRAME_BITS(FRAME_BITS),
    .LEAD_BITS (LEAD_BITS)
  ) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample   (fall_evt),
    .last     (last_fall),
    .sdata    (sdata),
    .result   (result),
    .frame_err(frame_err),
    .done     (done)
  );

  // ---------------- checker state ----------------
  logic            sclk_q;
  logic [RC_W-1:0] rise_cnt;
  logic [GC_W-1:0] gap_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q   <= 1'b0;
      rise_cnt <= '0;
      gap_cnt  <= GC_W'(GUARD_CYC + 1);
    end else begin
      sclk_q <= sclk;
      if (launch) rise_cnt <= '0;
      else if (sclk && !sclk_q) rise_cnt <= rise_cnt + 1'b1;
      if (fall_evt) gap_cnt <= '0;
      else if (gap_cnt != GC_W'(GUARD_CYC + 1)) gap_cnt <= gap_cnt + 1'b1;
    end
  end

  p_sclk_low_at_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cnv_n) |-> !sclk);

  p_sclk_quiet_conv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_busy |-> !sclk);

  p_pulse_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rise_cnt <= RC_W'(FRAME_BITS));

  p_full_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rise_cnt == RC_W'(FRAME_BITS)));

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(result) && $stable(frame_err)));

  p_guard_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cnv_n) |-> (gap_cnt >= GC_W'(GUARD_CYC)));

  p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !gen_active) |-> !sclk);

  initial begin
    p_width_ok_r4: assert (DATA_W >= 1 && LEAD_BITS >= 1 && GUARD_CYC >= 1
                           && CNV_LOW_CYC >= 2 && CONV_CYC > CNV_LOW_CYC);
  end

endmodule

// File: tb/sar_rd_host_tb.sv
`timescale 1ns/1ps
module sar_rd_host_tb;
  localparam int CONV_CYC  = 660;
  localparam int GUARD_CYC = 20;
  localparam int LOW_CYC   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_req = 1'b0;
  logic [3:0]  div_sel = 4'd0;
  logic        cnv_n, sclk, done, frame_err;
  logic        sdata = 1'b0;
  logic [11:0] result;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;

  // converter model state and measurements
  logic [15:0] word = 16'h0000;
  logic cnv_q = 1'b1, sclk_q = 1'b0;
  int nfall = 0, rises = 0, nconv = 0, sclk_viol = 0;
  int fall_cyc = 0, first_rise_cyc = 0, last_fall_cyc = -1000;
  int low_w = 0, conv_gap = 0, span = 0, start_gap = 0;

  sar_rd_host u_dut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .div_sel(div_sel),
    .cnv_n(cnv_n), .sclk(sclk), .sdata(sdata), .result(result),
    .done(done), .frame_err(frame_err)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  always @(sclk or cnv_n) begin
    if (cnv_n !== cnv_q) begin
      if (cnv_q === 1'b1 && cnv_n === 1'b0) begin
        nconv++;
        start_gap = cyc - last_fall_cyc;
        fall_cyc  = cyc;
        nfall = 0;
        rises = 0;
        if (sclk !== 1'b0) sclk_viol++;
      end else if (cnv_n === 1'b1) begin
        low_w = cyc - fall_cyc;
      end
      cnv_q = cnv_n;
    end
    if (sclk !== sclk_q) begin
      if (sclk === 1'b1) begin
        rises++;
        if (rises == 1) begin
          first_rise_cyc = cyc;
          conv_gap = cyc - fall_cyc;
          sdata = word[15];
        end
        if (rises > 16) sclk_viol++;
      end else if (sclk_q === 1'b1) begin
        nfall++;
        last_fall_cyc = cyc;
        span = cyc - first_rise_cyc;
        sdata = (nfall < 16) ? word[15 - nfall] : 1'b0;
      end
      sclk_q = sclk;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) begin seen = 1'b1; break; end
    end
  endtask

  // one complete read with every timing and data check
  task automatic t_read(input logic [15:0] w, input logic [3:0] dv);
    bit seen;
    int h;
    h = int'(dv) + 1;
    word = w;
    div_sel = dv;
    pulse_start();
    wait_done(seen);
    chk(seen, "R6", "done seen", int'(seen), 1);
    chk(result == w[11:0], "R4", "result", int'(result), int'(w[11:0]));
    chk(frame_err == (w[15:12] != 4'h0), "R5", "frame_err",
        int'(frame_err), int'(w[15:12] != 4'h0));
    chk(rises == 16, "R3", "pulse count", rises, 16);
    chk(span == 31 * h, "R3", "pulse span", span, 31 * h);
    chk(conv_gap == CONV_CYC + h, "R2", "conversion wait", conv_gap, CONV_CYC + h);
    chk(low_w == LOW_CYC, "R1", "strobe width", low_w, LOW_CYC);
    chk(sclk_viol == 0, "R2", "sclk high at start", sclk_viol, 0);
    @(negedge clk);
    chk(done == 1'b0, "R6", "done width", int'(done), 0);
    repeat (50) @(negedge clk);
    chk(result == w[11:0], "R6", "result hold", int'(result), int'(w[11:0]));
    chk(sclk == 1'b0, "R9", "sclk idle", int'(sclk), 0);
  endtask

  task automatic t_reset();
    chk(cnv_n == 1'b1, "R10", "cnv_n", int'(cnv_n), 1);
    chk(sclk == 1'b0, "R10", "sclk", int'(sclk), 0);
    chk(done == 1'b0, "R10", "done", int'(done), 0);
    chk(result == 12'h000, "R10", "result", int'(result), 0);
    chk(frame_err == 1'b0, "R10", "frame_err", int'(frame_err), 0);
  endtask

  // requests during a busy read merge into one follow-up conversion
  task automatic t_pending();
    bit seen;
    int c0;
    c0 = nconv;
    word = 16'h0A5A;
    div_sel = 4'd1;
    pulse_start();
    repeat (100) @(negedge clk);
    pulse_start();
    repeat (300) @(negedge clk);
    pulse_start();
    wait_done(seen);
    chk(result == 12'hA5A, "R4", "first of pair", int'(result), 12'hA5A);
    word = 16'h05A5;
    wait_done(seen);
    chk(seen, "R8", "pending served", int'(seen), 1);
    chk(result == 12'h5A5, "R4", "second of pair", int'(result), 12'h5A5);
    chk(start_gap == GUARD_CYC + 1, "R7", "guard gap", start_gap, GUARD_CYC + 1);
    repeat (2000) @(negedge clk);
    chk(nconv - c0 == 2, "R8", "conversions", nconv - c0, 2);
    chk(sclk == 1'b0 && cnv_n == 1'b1, "R9", "quiet after pair",
        int'({sclk, cnv_n}), 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(nconv == 0, "R9", "no start without request", nconv, 0);
    t_read(16'h0ABC, 4'd0);
    t_read(16'h0FFF, 4'd3);
    t_read(16'h0000, 4'd0);
    t_read(16'h0555, 4'd2);
    t_read(16'hF123, 4'd0);
    t_read(16'h1800, 4'd1);
    t_read(16'h8001, 4'd0);
    t_read(16'h0801, 4'd0);
    t_pending();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule